// File: doc/BRIEF.md
# Shared-Done Two-Client Mutex Arbiter

This block grants one of two clients exclusive use of a shared resource. All handshake lines use transition signalling: every event on a line is a change of its level, not a pulse. A client asks for the resource by flipping its request line. The arbiter answers by flipping that client's grant line. Both clients share one done line, and a flip on it closes whichever grant is currently open.

The arbiter samples its inputs on the clock and finds events by comparing each sampled level with the level sampled one cycle earlier. While one client holds the grant, a request from the other client is held as pending. When both clients are waiting at the same decision point, a pointer picks the winner and then moves to the other client, so neither client can be starved.

Handshake misuse sets a sticky error flag, and once that flag is set no further grants are issued until reset. Misuse means a done with no grant open, or a second request from a client that already has a request pending or a grant open. A busy output and a pending vector show the arbiter's state.

Top module: `shdone_arbiter`

## Requirements
- R1: On synchronous active-high reset, both grant outputs, busy, pending and error go low and the tie pointer favours client 0. The input levels present during reset become the baseline, so a level that changed while reset was high is not taken as an event.
- R2: A request flip sampled at clock edge k, with no grant open and no error, flips that client's grant output at edge k+1 and raises busy at the same edge.
- R3: A done flip sampled while a grant is open closes that grant. With nothing pending, busy is low one edge after the done is sampled, and the grant output keeps its level.
- R4: While a grant is open and no done arrives, neither grant output changes. At most one grant is open at any time.
- R5: A request that waits behind an open grant is granted on the same edge at which the done closing the open grant is processed.
- R6: When both clients are waiting at one decision, the client named by the tie pointer wins (client 0 after reset) and the pointer moves to the other client. Two ties in a row are therefore won by different clients.
- R7: A done flip and a new request flip from the client that owns the open grant may be sampled in the same cycle. The done is applied first, the request is accepted without error, and the client is granted again.
- R8: A done flip while no grant is open sets the error output. The error stays high until reset, and while it is high no grant output changes.
- R9: A request flip from a client that already has a request pending, or that holds the open grant with no done in the same cycle, sets the error output.
- R10: Bit i of the pending output is high exactly while client i has a request that has been accepted but not yet granted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req0_i | input | 1 | Client 0 request line, one event per flip |
| req1_i | input | 1 | Client 1 request line, one event per flip |
| done_i | input | 1 | Shared done line, one event per flip |
| gnt0_o | output | 1 | Client 0 grant line, flips once per grant |
| gnt1_o | output | 1 | Client 1 grant line, flips once per grant |
| busy_o | output | 1 | High while a grant is open |
| pend_o | output | 2 | Waiting requests, bit i for client i |
| err_o | output | 1 | Sticky protocol error flag |

## Verification
The bench builds the block with its default parameters, that is two clients and a one-bit line per event source. With only two clients, every path through the arbiter can be reached with directed tests: a single grant, a request waiting behind an open grant, both tie outcomes back to back, a done and a request from the owner in the same cycle, and each of the three kinds of misuse. Grant levels are tracked in the bench as expected toggles. Each case is sampled at the second clock edge after its stimulus, and after an error the bench confirms that the grant outputs stay frozen.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int unsigned NUM_CLIENTS = 2;
  localparam int unsigned IDX_W = (NUM_CLIENTS > 1) ? $clog2(NUM_CLIENTS) : 1;

  typedef logic [NUM_CLIENTS-1:0] client_vec_t;
  typedef logic [IDX_W-1:0]       client_idx_t;

  // Winner among waiting clients: the pointer decides a tie,
  // otherwise the only waiting client wins.
  function automatic client_idx_t pick_winner(client_vec_t waiting, client_idx_t ptr);
    client_idx_t w;
    w = '0;
    if (&waiting) w = ptr;
    else if (waiting[1]) w = client_idx_t'(1);
    else w = '0;
    return w;
  endfunction

  // Pointer after a tie: move to the client that lost.
  function automatic client_idx_t next_ptr(client_idx_t winner);
    return client_idx_t'(~winner);
  endfunction
endpackage

// File: rtl/edge_sense.sv
module edge_sense #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] ev_o
);
  logic [W-1:0] samp_q;
  logic [W-1:0] prev_q;

  for (genvar i = 0; i < W; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) begin
        samp_q[i] <= lvl_i[i];
        prev_q[i] <= lvl_i[i];
      end else begin
        samp_q[i] <= lvl_i[i];
        prev_q[i] <= samp_q[i];
      end
    end
    assign ev_o[i] = samp_q[i] ^ prev_q[i];
  end
endmodule

// File: rtl/mutex_core.sv
module mutex_core
  import arb_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  client_vec_t req_ev,
  input  logic        done_ev,
  output client_vec_t gnt_o,
  output logic        busy_o,
  output client_vec_t pend_o,
  output logic        err_o
);
  client_vec_t gnt_q, pend_q;
  logic        busy_q, err_q;
  client_idx_t owner_q, ptr_q;

  // Named internal events for the assertions.
  logic        open_kept, bad_done, err_n, tie;
  client_vec_t bad_req, pend_all, grant_fire;
  client_idx_t win;

  always_comb begin
    open_kept = busy_q & ~done_ev;
    bad_done  = done_ev & ~busy_q;
    for (int i = 0; i < NUM_CLIENTS; i++) begin
      bad_req[i] = req_ev[i] &
                   (pend_q[i] | (open_kept & (owner_q == client_idx_t'(i))));
    end
    err_n      = err_q | bad_done | (|bad_req);
    pend_all   = pend_q | req_ev;
    win        = pick_winner(pend_all, ptr_q);
    grant_fire = '0;
    tie        = 1'b0;
    if (!err_n && !open_kept && (|pend_all)) begin
      grant_fire[win] = 1'b1;
      tie             = &pend_all;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gnt_q   <= '0;
      pend_q  <= '0;
      busy_q  <= 1'b0;
      err_q   <= 1'b0;
      owner_q <= '0;
      ptr_q   <= '0;
    end else begin
      err_q <= err_n;
      if (!err_n) begin
        pend_q <= pend_all & ~grant_fire;
        gnt_q  <= gnt_q ^ grant_fire;
        busy_q <= open_kept | (|grant_fire);
        if (|grant_fire) owner_q <= win;
        if (tie) ptr_q <= next_ptr(win);
      end
    end
  end

  assign gnt_o  = gnt_q;
  assign busy_o = busy_q;
  assign pend_o = pend_q;
  assign err_o  = err_q;

  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !done_ev) |=> $stable(gnt_q))
    else $error("R4: grant changed while another grant was open");

  p_done_closes_r3: assert property (@(posedge clk) disable iff (rst)
    (busy_q && done_ev && !err_q && (req_ev == '0) && (pend_q == '0)) |=> !busy_q)
    else $error("R3: done did not close the open grant");

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    err_q |=> err_q)
    else $error("R8: error flag dropped without reset");

  p_frozen_r8: assert property (@(posedge clk) disable iff (rst)
    err_q |=> $stable(gnt_q))
    else $error("R8: grant changed after error");

  p_tie_r6: assert property (@(posedge clk) disable iff (rst)
    tie |=> (ptr_q != $past(ptr_q)))
    else $error("R6: tie pointer did not move");

  p_busy_grant_r2: assert property (@(posedge clk) disable iff (rst)
    (grant_fire != '0) |=> busy_q)
    else $error("R2: busy not raised after grant");
endmodule

// File: rtl/shdone_arbiter.sv
module shdone_arbiter
  import arb_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       req0_i,
  input  logic       req1_i,
  input  logic       done_i,
  output logic       gnt0_o,
  output logic       gnt1_o,
  output logic       busy_o,
  output logic [1:0] pend_o,
  output logic       err_o
);
  localparam int unsigned LINES = NUM_CLIENTS + 1;

  logic [LINES-1:0] lvl, ev;
  client_vec_t      gnt, pend;

  assign lvl = {done_i, req1_i, req0_i};

  edge_sense #(.W(LINES)) u_sense (
    .clk  (clk),
    .rst  (rst),
    .lvl_i(lvl),
    .ev_o (ev)
  );

  mutex_core u_core (
    .clk    (clk),
    .rst    (rst),
    .req_ev (ev[NUM_CLIENTS-1:0]),
    .done_ev(ev[NUM_CLIENTS]),
    .gnt_o  (gnt),
    .busy_o (busy_o),
    .pend_o (pend),
    .err_o  (err_o)
  );

  assign gnt0_o = gnt[0];
  assign gnt1_o = gnt[1];
  assign pend_o = pend;
endmodule

// File: tb/shdone_arbiter_bench.sv
module shdone_arbiter_bench;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req0 = 1'b0, req1 = 1'b0, done = 1'b0;
  logic gnt0, gnt1, busy, err;
  logic [1:0] pend;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  logic eg0 = 1'b0, eg1 = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  shdone_arbiter u_shdone_arbiter (
    .clk(clk), .rst(rst), .req0_i(req0), .req1_i(req1), .done_i(done),
    .gnt0_o(gnt0), .gnt1_o(gnt1), .busy_o(busy), .pend_o(pend), .err_o(err)
  );

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_state(string req, logic b, logic [1:0] p, logic e);
    check(req, "gnt0", gnt0, eg0);
    check(req, "gnt1", gnt1, eg1);
    check(req, "busy", busy, b);
    check(req, "pend", pend, p);
    check(req, "err", err, e);
  endtask

  // Inputs change at a falling edge; results are read at the falling
  // edge after two rising edges (sampling register, then state).
  task automatic settle();
    @(posedge clk); @(posedge clk); @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    req0 = ~req0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    eg0 = 1'b0; eg1 = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    check_state("R1", 1'b0, 2'b00, 1'b0);
  endtask

  task automatic t_single();
    req0 = ~req0; settle(); eg0 = ~eg0;
    check_state("R2", 1'b1, 2'b00, 1'b0);
    done = ~done; settle();
    check_state("R3", 1'b0, 2'b00, 1'b0);
  endtask

  task automatic t_wait();
    req0 = ~req0; settle(); eg0 = ~eg0;
    req1 = ~req1; settle();
    check_state("R4 R10", 1'b1, 2'b10, 1'b0);
    done = ~done; settle(); eg1 = ~eg1;
    check_state("R5", 1'b1, 2'b00, 1'b0);
    done = ~done; settle();
    check_state("R3", 1'b0, 2'b00, 1'b0);
  endtask

  task automatic t_ties();
    req0 = ~req0; req1 = ~req1; settle(); eg0 = ~eg0;
    check_state("R6 first tie", 1'b1, 2'b10, 1'b0);
    done = ~done; settle(); eg1 = ~eg1;
    check_state("R6 loser served", 1'b1, 2'b00, 1'b0);
    done = ~done; settle();
    req0 = ~req0; req1 = ~req1; settle(); eg1 = ~eg1;
    check_state("R6 second tie", 1'b1, 2'b01, 1'b0);
    done = ~done; settle(); eg0 = ~eg0;
    check_state("R6 R10", 1'b1, 2'b00, 1'b0);
    done = ~done; settle();
    check_state("R6 idle", 1'b0, 2'b00, 1'b0);
  endtask

  task automatic t_overlap();
    req0 = ~req0; settle(); eg0 = ~eg0;
    done = ~done; req0 = ~req0; settle(); eg0 = ~eg0;
    check_state("R7", 1'b1, 2'b00, 1'b0);
    done = ~done; settle();
    check_state("R7 idle", 1'b0, 2'b00, 1'b0);
  endtask

  task automatic t_rereq_open();
    req1 = ~req1; settle(); eg1 = ~eg1;
    req1 = ~req1; settle();
    check("R9", "err owner re-request", err, 1);
    done = ~done; req0 = ~req0; settle();
    check_state("R8 frozen", busy, pend, 1'b1);
  endtask

  task automatic t_rereq_pend();
    do_reset();
    req0 = ~req0; settle(); eg0 = ~eg0;
    req1 = ~req1; settle();
    check("R10", "pend", pend, 2);
    req1 = ~req1; settle();
    check("R9", "err pending re-request", err, 1);
    check("R9", "gnt1 unchanged", gnt1, eg1);
  endtask

  task automatic t_stray_done();
    do_reset();
    done = ~done; settle();
    check("R8", "err stray done", err, 1);
    req0 = ~req0; settle();
    check_state("R8 no grant", 1'b0, 2'b00, 1'b1);
  endtask

  initial begin
    #(CLK_P * 20000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_single();
    t_wait();
    t_ties();
    t_overlap();
    t_rereq_open();
    t_rereq_pend();
    t_stray_done();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule